// File: doc/BRIEF.md
# Fractional Reference Clock Divider

This block makes a reference clock from one of several input clocks. It divides the selected source by twice a divisor that has an integer part and a fractional part. The integer part N is a 15-bit field. The fractional part M is a 9-bit trim, counted in steps of 1/512. The divider counts rising edges of the selected source. It toggles the output after each half-period. The fraction is made by adding the trim to a 9-bit accumulator once per half-period. When the accumulator carries out, the next half-period is one source cycle longer. Over many periods the output therefore alternates between the two nearest whole lengths, and the average period is 2·(N + M/512) source cycles.

Software writes new divisor and trim values into shadow registers. A self-clearing switch request moves both values into the running divider together, at an output period boundary. A status bit shows whether the divider is active. The source select can be changed only while that bit is low. An output-enable bit forces the pin low while the divider keeps running. With a divisor of zero the selected source goes straight to the pin.

The source inputs are sampled in the block's own clock domain. This clock must be fast enough to see every level of each source.

Top module: `frac_refclk_div`

## Requirements
- R1: After reset, the control register at offset 0x00 and the trim register at offset 0x10 both read 0, and `ref_pin` is low.
- R2: Control register layout:
  - bits 3:0 are the source select;
  - bit 8 is the read-only active flag;
  - bit 9 is the switch request;
  - bit 12 is the output enable;
  - bit 15 is the on bit;
  - bits 30:16 are the shadow divisor N.

  The trim register holds the shadow trim M in bits 31:23. Every other bit reads 0, and reads at any other offset return 0.
- R3: While dividing with N>0, output half-period h (counted from 0 after turn-on; half 0 is low) lasts N + floor(h·M/512) − floor((h−1)·M/512) source cycles for h ≥ 1.
- R4: With a running divisor of 0, the pin follows the selected source level. The trim has no effect in this case.
- R5: Writing N or M without a switch request does not change the output timing. Read-back returns the shadow value.
- R6: Writing 1 to bit 9 sets a request that reads 1 until it is applied. When the divider is idle or in pass-through, the request is applied at once. While the divider is running, it is applied at the end of the current high half-period. From then on, the next half-period uses the new N and M, and the accumulator restarts from 0.
- R7: A write to the source select is ignored while the active flag is 1.
- R8: The active flag is 1 while the block is on, or while the output is still high after being turned off. After turn-off, the current high half-period completes at full length and the pin then stays low.
- R9: With the output enable at 0, the pin is low, the active flag stays 1 and the divider keeps counting. When the enable is set again, the half-periods continue at their programmed length.
- R10: Select value s counts rising edges of `src_clk[s]`. A select value of NSRC or above selects no source, so the output never toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all sources are sampled with it |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte offset (0x00 control, 0x10 trim) |
| reg_wr | input | 1 | Write strobe for `reg_wdata` at `reg_addr` |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| src_clk | input | NSRC | Candidate source clocks, as sampled levels |
| ref_pin | output | 1 | Reference clock output |

## Verification
The bench builds the block with NSRC=3, so select value 3 is out of range and the no-source case is reachable. The other parameters stay at their defaults. Three sources with periods of 2, 6 and 10 clocks let the bench convert each source period directly into a clock-cycle length. The bench sweeps N over {1,2,3,7} and M over seven trims from 0 to 511. For each setting it compares ten consecutive half-periods with the floor formula. This covers trims that never carry, trims that carry on every other half, and trims that carry almost every half.

// File: rtl/frac_refclk_pkg.sv
package frac_refclk_pkg;
    localparam int          REG_W    = 32;
    localparam int          ADDR_W   = 8;
    localparam logic [7:0]  CTRL_OFS = 8'h00;
    localparam logic [7:0]  TRIM_OFS = 8'h10;
    localparam int          SEL_W    = 4;
    localparam int          SEL_LSB  = 0;
    localparam int          ACT_BIT  = 8;
    localparam int          SWR_BIT  = 9;
    localparam int          OE_BIT   = 12;
    localparam int          ON_BIT   = 15;
    localparam int          DIV_LSB  = 16;
    localparam int          TRIM_LSB = 23;
endpackage

// File: rtl/frac_refclk_regs.sv
module frac_refclk_regs
    import frac_refclk_pkg::*;
#(
    parameter int DIV_W  = 15,
    parameter int TRIM_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic                active,
    input  logic                apply,
    output logic                on,
    output logic                oe,
    output logic [SEL_W-1:0]    sel,
    output logic [DIV_W-1:0]    div_sh,
    output logic [TRIM_W-1:0]   trim_sh,
    output logic                pend
);
    typedef struct packed {
        logic               on;
        logic               oe;
        logic [SEL_W-1:0]   sel;
        logic [DIV_W-1:0]   div;
        logic [TRIM_W-1:0]  trim;
        logic               pend;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  unused_wbits;

    assign unused_wbits = ^reg_wdata;

    always_comb begin
        regs_d = regs_q;
        if (apply) begin
            regs_d.pend = 1'b0;
        end
        if (reg_wr && reg_addr == CTRL_OFS) begin
            regs_d.on  = reg_wdata[ON_BIT];
            regs_d.oe  = reg_wdata[OE_BIT];
            regs_d.div = reg_wdata[DIV_LSB +: DIV_W];
            if (!active) begin
                regs_d.sel = reg_wdata[SEL_LSB +: SEL_W];
            end
            if (reg_wdata[SWR_BIT]) begin
                regs_d.pend = 1'b1;
            end
        end
        if (reg_wr && reg_addr == TRIM_OFS) begin
            regs_d.trim = reg_wdata[TRIM_LSB +: TRIM_W];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_OFS) begin
            reg_rdata[SEL_LSB +: SEL_W] = regs_q.sel;
            reg_rdata[ACT_BIT]          = active;
            reg_rdata[SWR_BIT]          = regs_q.pend;
            reg_rdata[OE_BIT]           = regs_q.oe;
            reg_rdata[ON_BIT]           = regs_q.on;
            reg_rdata[DIV_LSB +: DIV_W] = regs_q.div;
        end else if (reg_addr == TRIM_OFS) begin
            reg_rdata[TRIM_LSB +: TRIM_W] = regs_q.trim;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign on      = regs_q.on;
    assign oe      = regs_q.oe;
    assign sel     = regs_q.sel;
    assign div_sh  = regs_q.div;
    assign trim_sh = regs_q.trim;
    assign pend    = regs_q.pend;
endmodule

// File: rtl/frac_refclk_srcsel.sv
module frac_refclk_srcsel
    import frac_refclk_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_clk,
    input  logic [SEL_W-1:0] sel,
    output logic             lvl,
    output logic             tick
);
    typedef struct packed {
        logic [NSRC-1:0] smp;
        logic [NSRC-1:0] old;
    } samp_t;

    samp_t           samp_d, samp_q;
    logic [NSRC-1:0] rise;

    for (genvar g = 0; g < NSRC; g++) begin : g_edge
        assign rise[g] = samp_q.smp[g] & ~samp_q.old[g];
    end

    always_comb begin
        samp_d.smp = src_clk;
        samp_d.old = samp_q.smp;
    end

    always_comb begin
        lvl  = 1'b0;
        tick = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == SEL_W'(i)) begin
                lvl  = samp_q.smp[i];
                tick = rise[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= '0;
        end else begin
            samp_q <= samp_d;
        end
    end
endmodule

// File: rtl/frac_refclk_core.sv
module frac_refclk_core #(
    parameter int DIV_W  = 15,
    parameter int TRIM_W = 9,
    localparam int CNT_W = DIV_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              on,
    input  logic              oe,
    input  logic              tick,
    input  logic              lvl,
    input  logic [DIV_W-1:0]  div_sh,
    input  logic [TRIM_W-1:0] trim_sh,
    input  logic              pend,
    output logic              apply,
    output logic              active,
    output logic [DIV_W-1:0]  div_live,
    output logic [CNT_W-1:0]  cnt,
    output logic              ref_pin
);
    typedef struct packed {
        logic               ref_lvl;
        logic               ext;
        logic [TRIM_W-1:0]  acc;
        logic [CNT_W-1:0]   cnt;
        logic [DIV_W-1:0]   div;
        logic [TRIM_W-1:0]  trim;
    } div_t;

    div_t              div_d, div_q;
    logic              pass;
    logic              running;
    logic              boundary;
    logic [CNT_W-1:0]  cnt_n;
    logic [CNT_W-1:0]  half_len;
    logic [TRIM_W:0]   acc_sum;

    always_comb begin
        div_d    = div_q;
        apply    = 1'b0;
        boundary = 1'b0;
        pass     = (div_q.div == '0);
        running  = on | div_q.ref_lvl;
        cnt_n    = div_q.cnt + CNT_W'(1);
        half_len = {1'b0, div_q.div} + {{(CNT_W-1){1'b0}}, div_q.ext};
        acc_sum  = {1'b0, div_q.acc} + {1'b0, div_q.trim};

        if (pass || !running) begin
            div_d.ref_lvl = 1'b0;
            div_d.cnt     = '0;
            div_d.acc     = '0;
            div_d.ext     = 1'b0;
        end else if (tick) begin
            if (cnt_n == half_len) begin
                div_d.ref_lvl = ~div_q.ref_lvl;
                div_d.cnt     = '0;
                div_d.acc     = acc_sum[TRIM_W-1:0];
                div_d.ext     = acc_sum[TRIM_W];
                boundary      = div_q.ref_lvl;
            end else begin
                div_d.cnt = cnt_n;
            end
        end

        if (pend && (pass || !running || boundary)) begin
            apply         = 1'b1;
            div_d.div     = div_sh;
            div_d.trim    = trim_sh;
            div_d.acc     = '0;
            div_d.ext     = 1'b0;
            div_d.cnt     = '0;
            div_d.ref_lvl = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign active   = on | div_q.ref_lvl;
    assign div_live = div_q.div;
    assign cnt      = div_q.cnt;
    assign ref_pin  = oe & (pass ? (on & lvl) : div_q.ref_lvl);
endmodule

// File: rtl/frac_refclk_div.sv
module frac_refclk_div
    import frac_refclk_pkg::*;
#(
    parameter int NSRC   = 4,
    parameter int DIV_W  = 15,
    parameter int TRIM_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NSRC-1:0]   src_clk,
    output logic              ref_pin
);
    localparam int CNT_W = DIV_W + 1;

    logic              on;
    logic              oe;
    logic [SEL_W-1:0]  sel;
    logic [DIV_W-1:0]  div_sh;
    logic [TRIM_W-1:0] trim_sh;
    logic              pend;
    logic              apply;
    logic              active;
    logic              lvl;
    logic              tick;
    logic [DIV_W-1:0]  div_live;
    logic [CNT_W-1:0]  cnt;

    frac_refclk_regs #(.DIV_W(DIV_W), .TRIM_W(TRIM_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .active    (active),
        .apply     (apply),
        .on        (on),
        .oe        (oe),
        .sel       (sel),
        .div_sh    (div_sh),
        .trim_sh   (trim_sh),
        .pend      (pend)
    );

    frac_refclk_srcsel #(.NSRC(NSRC)) u_src (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_clk (src_clk),
        .sel     (sel),
        .lvl     (lvl),
        .tick    (tick)
    );

    frac_refclk_core #(.DIV_W(DIV_W), .TRIM_W(TRIM_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .on       (on),
        .oe       (oe),
        .tick     (tick),
        .lvl      (lvl),
        .div_sh   (div_sh),
        .trim_sh  (trim_sh),
        .pend     (pend),
        .apply    (apply),
        .active   (active),
        .div_live (div_live),
        .cnt      (cnt),
        .ref_pin  (ref_pin)
    );
endmodule

// File: rtl/frac_refclk_chk.sv
module frac_refclk_chk #(
    parameter int SEL_W = 4,
    parameter int DIV_W = 15,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic             pend,
    input logic             apply,
    input logic             active,
    input logic [SEL_W-1:0] sel,
    input logic [DIV_W-1:0] div_live,
    input logic [CNT_W-1:0] cnt,
    input logic             ref_pin
);
    // R6
    apply_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        apply |-> pend);

    // R6
    req_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> (!pend || $past(reg_wr)));

    // R7
    sel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> $stable(sel));

    // R5
    live_div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> $stable(div_live));

    // R8
    idle_pin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> !ref_pin);

    // R3
    half_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_live != '0) |-> (cnt <= CNT_W'(div_live)));
endmodule

bind frac_refclk_div frac_refclk_chk #(
    .SEL_W (frac_refclk_pkg::SEL_W),
    .DIV_W (DIV_W),
    .CNT_W (DIV_W + 1)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .pend     (pend),
    .apply    (apply),
    .active   (active),
    .sel      (sel),
    .div_live (div_live),
    .cnt      (cnt),
    .ref_pin  (ref_pin)
);

// File: tb/frac_refclk_div_tb.sv
module frac_refclk_div_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC       = 3;
    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_TRIM = 8'h10;
    localparam int MAXE = 2048;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      reg_addr = '0;
    logic            reg_wr = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;
    logic [NSRC-1:0] src_clk = '0;
    logic            ref_pin;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    int ne = 0;
    int edge_t [MAXE];
    logic prev_pin = 1'b0;

    frac_refclk_div #(.NSRC(NSRC)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .src_clk   (src_clk),
        .ref_pin   (ref_pin)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // sources: periods of 2, 6 and 10 clocks
    initial begin
        int c1 = 0;
        int c2 = 0;
        forever begin
            @(negedge clk);
            src_clk[0] = ~src_clk[0];
            c1++;
            if (c1 == 3) begin c1 = 0; src_clk[1] = ~src_clk[1]; end
            c2++;
            if (c2 == 5) begin c2 = 0; src_clk[2] = ~src_clk[2]; end
        end
    end

    // pin edge logger, sampling shortly after each rising clock edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            cyc++;
            if (ref_pin !== prev_pin) begin
                if (ne < MAXE) edge_t[ne] = cyc;
                ne++;
            end
            prev_pin = ref_pin;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit on, input bit oe, input int sel,
                                       input int dv, input bit sw);
        logic [31:0] w;
        w = '0;
        w[3:0]   = sel[3:0];
        w[9]     = sw;
        w[12]    = oe;
        w[15]    = on;
        w[30:16] = dv[14:0];
        return w;
    endfunction

    function automatic int exp_half(input int n, input int m, input int h);
        return n + (h * m) / 512 - ((h - 1) * m) / 512;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_inactive();
        logic [31:0] v;
        int t = 0;
        rd(A_CTRL, v);
        while (v[8] && t < 3000) begin
            rd(A_CTRL, v);
            t++;
        end
        chk("R8 active flag drops after turn-off", longint'(v[8]), 0);
    endtask

    task automatic wait_ne(input int target);
        int t = 0;
        while (ne < target && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk("edge arrival timeout", longint'(ne >= target), 1);
    endtask

    task automatic wait_rise();
        int t = 0;
        while (ref_pin !== 1'b0 && t < 3000) begin @(negedge clk); t++; end
        while (ref_pin !== 1'b1 && t < 6000) begin @(negedge clk); t++; end
    endtask

    task automatic setup(input int n, input int m, input int sel);
        wr(A_CTRL, mk(0, 1, sel, n, 0));
        wait_inactive();
        wr(A_TRIM, 32'(m) << 23);
        wr(A_CTRL, mk(0, 1, sel, n, 1));
        wr(A_CTRL, mk(1, 1, sel, n, 0));
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int b;
        int nv [4] = '{1, 2, 3, 7};
        int mv [7] = '{0, 1, 128, 255, 256, 384, 511};

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CTRL, v); chk("R1 control reset", v, 0);
        rd(A_TRIM, v); chk("R1 trim reset", v, 0);
        chk("R1 pin low after reset", ref_pin, 0);

        // R2 field layout, reserved bits read zero
        wr(A_CTRL, 32'hFFFF_7DFF);
        rd(A_CTRL, v); chk("R2 control layout", v, 32'h7FFF_100F);
        wr(A_TRIM, 32'hFFFF_FFFF);
        rd(A_TRIM, v); chk("R2 trim layout", v, 32'hFF80_0000);
        rd(8'h04, v);  chk("R2 unmapped offset", v, 0);
        wr(A_CTRL, 32'h0);
        wr(A_TRIM, 32'h0);

        // R3 sweep of divisor and trim, R6 immediate apply while idle
        for (int ni = 0; ni < 4; ni++) begin
            for (int mi = 0; mi < 7; mi++) begin
                wr(A_CTRL, mk(0, 1, 0, nv[ni], 0));
                wait_inactive();
                wr(A_TRIM, 32'(mv[mi]) << 23);
                wr(A_CTRL, mk(0, 1, 0, nv[ni], 1));
                rd(A_CTRL, v);
                chk("R6 request applied at once while idle", longint'(v[9]), 0);
                wr(A_CTRL, mk(1, 1, 0, nv[ni], 0));
                b = ne;
                wait_ne(b + 11);
                for (int j = 0; j < 10; j++) begin
                    chk($sformatf("R3 N=%0d M=%0d half %0d", nv[ni], mv[mi], j + 1),
                        edge_t[b + j + 1] - edge_t[b + j],
                        2 * exp_half(nv[ni], mv[mi], j + 1));
                end
            end
        end

        // R5 shadow write without request leaves timing unchanged
        setup(3, 0, 0);
        wr(A_CTRL, mk(1, 1, 0, 9, 0));
        wr(A_TRIM, 32'(200) << 23);
        rd(A_CTRL, v); chk("R5 shadow divisor read-back", v[30:16], 9);
        b = ne;
        wait_ne(b + 5);
        for (int j = 0; j < 4; j++) begin
            chk("R5 timing kept without request", edge_t[b + j + 1] - edge_t[b + j], 6);
        end

        // R6 request while running applies at the end of the high half
        wr(A_TRIM, 32'h0);
        wait_rise();
        b = ne;
        wr(A_CTRL, mk(1, 1, 0, 9, 1));
        rd(A_CTRL, v); chk("R6 request pending while running", longint'(v[9]), 1);
        wait_ne(b + 3);
        chk("R6 high half keeps old divisor", edge_t[b] - edge_t[b - 1], 6);
        chk("R6 next low half uses new divisor", edge_t[b + 1] - edge_t[b], 18);
        chk("R6 following high half new divisor", edge_t[b + 2] - edge_t[b + 1], 18);
        rd(A_CTRL, v); chk("R6 request self-clears", longint'(v[9]), 0);

        // R8 turn-off completes the high half, then idles
        setup(3, 0, 0);
        wait_rise();
        b = ne;
        wr(A_CTRL, mk(0, 1, 0, 3, 0));
        rd(A_CTRL, v); chk("R8 active while finishing period", longint'(v[8]), 1);
        wait_ne(b + 1);
        chk("R8 final high half full length", edge_t[b] - edge_t[b - 1], 6);
        repeat (60) @(negedge clk);
        chk("R8 no edges after final period", ne, b + 1);
        chk("R8 pin low when stopped", ref_pin, 0);
        rd(A_CTRL, v); chk("R8 active clear when stopped", longint'(v[8]), 0);

        // R9 output enable low gates the pin only
        wr(A_CTRL, mk(1, 0, 0, 3, 0));
        b = ne;
        repeat (80) @(negedge clk);
        chk("R9 no pin edges with enable low", ne, b);
        chk("R9 pin low with enable low", ref_pin, 0);
        rd(A_CTRL, v); chk("R9 active with enable low", longint'(v[8]), 1);
        wr(A_CTRL, mk(1, 1, 0, 3, 0));
        b = ne;
        wait_ne(b + 3);
        chk("R9 divider kept running half 1", edge_t[b + 1] - edge_t[b], 6);
        chk("R9 divider kept running half 2", edge_t[b + 2] - edge_t[b + 1], 6);

        // R4 pass-through with divisor zero, trim ignored
        setup(0, 5, 1);
        b = ne;
        wait_ne(b + 5);
        for (int j = 0; j < 4; j++) begin
            chk("R4 pin follows source", edge_t[b + j + 1] - edge_t[b + j], 3);
        end

        // R10 source selection
        setup(1, 0, 1);
        b = ne;
        wait_ne(b + 3);
        chk("R10 source 1 half", edge_t[b + 1] - edge_t[b], 6);
        chk("R10 source 1 half b", edge_t[b + 2] - edge_t[b + 1], 6);
        setup(1, 0, 2);
        b = ne;
        wait_ne(b + 3);
        chk("R10 source 2 half", edge_t[b + 1] - edge_t[b], 10);
        setup(1, 0, 3);
        b = ne;
        repeat (80) @(negedge clk);
        chk("R10 out-of-range select gives no edges", ne, b);
        rd(A_CTRL, v); chk("R10 block on with no source", longint'(v[8]), 1);

        // R7 select frozen while active
        wr(A_CTRL, mk(1, 1, 0, 1, 0));
        rd(A_CTRL, v); chk("R7 select write ignored while active", v[3:0], 3);
        wr(A_CTRL, mk(0, 1, 0, 1, 0));
        wait_inactive();
        wr(A_CTRL, mk(0, 1, 2, 1, 0));
        rd(A_CTRL, v); chk("R7 select write taken while inactive", v[3:0], 2);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule